// File: doc/BRIEF.md
# Destination Address Filter with Station Address Registers

This block decides, frame by frame, whether an incoming network frame is addressed to this station. Software programs a six-byte station address through two 32-bit registers. Frame bytes arrive one per cycle. Each byte comes with a valid qualifier, the first byte is flagged by a start strobe and the last byte by an end strobe. The filter compares the first six bytes, which are the destination, against the stored address and against the all-ones broadcast address.

The filter waits until the 14-byte header has fully arrived. It then raises a single one-cycle verdict pulse that says accept or reject. A frame that ends before its header is complete is rejected at its last byte, whatever its destination. Two mode inputs change the decision. Promiscuous mode accepts every frame that carries a full header. Broadcast rejection refuses frames sent to the all-ones address. Both mode inputs are sampled when the frame starts.

Top module: `mac_dest_filter`

## Requirements
- R1: Writing the low register (regSel=0) stores address bytes 0..3, with byte 0 in bits 7:0, byte 1 in 15:8, byte 2 in 23:16 and byte 3 in 31:24. The written value reads back on regRdData from the cycle after the write.
- R2: Writing the high register (regSel=1) stores address byte 4 from bits 7:0 and byte 5 from bits 15:8. Bits 31:16 of that register always read as zero.
- R3: After reset both registers read zero and verdictValid is low.
- R4: With promiscuous mode off, a frame whose destination bytes equal the station address is accepted. The first received byte is compared with address byte 0, and so on up to byte 5.
- R5: A destination that differs from the station address in any byte, including the first or the last, is rejected unless R6 or R7 accepts it.
- R6: A destination of six 0xFF bytes is accepted while bcastReject is 0 and rejected while it is 1. A station-address match is accepted regardless of bcastReject.
- R7: With promiscuous mode on, every frame of at least 14 bytes is accepted, whatever its destination.
- R8: A frame of fewer than 14 bytes is rejected, even under promiscuous mode or with a matching destination. Its verdict appears in the cycle after its end byte.
- R9: Each frame produces exactly one verdict, a one-cycle verdictValid pulse. For a frame of 14 or more bytes it appears in the cycle after the 14th valid byte. verdictAccept is high only together with verdictValid.
- R10: The mode inputs are sampled with the start byte. Changes to them during the frame do not alter that frame's verdict.
- R11: A start strobe in the middle of a frame abandons the current evaluation. The new frame is judged alone and gets one verdict.
- R12: Cycles with rxValid low inside a frame are not counted as bytes. They only delay the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 low address word, 1 high address word |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Packed read image of the selected register |
| promiscMode | input | 1 | Accept every frame with a full header |
| bcastReject | input | 1 | Refuse frames sent to the broadcast address |
| rxValid | input | 1 | rxByte carries a frame byte this cycle |
| rxSof | input | 1 | This byte is the first of a frame |
| rxEof | input | 1 | This byte is the last of a frame |
| rxByte | input | 8 | Frame byte |
| verdictValid | output | 1 | One-cycle verdict pulse |
| verdictAccept | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
Some properties are checked on every cycle. An accept never appears without a verdict pulse. The upper half of the high register always reads zero. A low-register write is visible on the next read. A one-byte frame always yields an immediate reject. A frame's opening byte never produces a verdict unless that byte also ends the frame. Other behaviour can only be shown by the bench's scenarios: the byte order of the comparison, broadcast handling under each mode, promiscuous acceptance, the short-frame rule, mode changes during a frame being ignored, restarts in the middle of a frame, and the exact verdict cycle when valid gaps are present.

// File: rtl/macflt_pkg.sv
package macflt_pkg;
  // strobes from the frame sequencer to the match datapath
  typedef struct packed {
    logic startFrame;   // first byte of a frame: latch modes, reseed flags
    logic cmpEn;        // current byte is a destination byte
    logic issue;        // produce the verdict at this edge
    logic forceReject;  // verdict is a short-frame reject
  } ctrlStrobes_t;
endpackage

// File: rtl/macflt_ctrl.sv
module macflt_ctrl
  import macflt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HDR_LEN    = 14
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          rxValid,
  input  logic                          rxSof,
  input  logic                          rxEof,
  output ctrlStrobes_t                  strb,
  output logic [$clog2(ADDR_BYTES)-1:0] cmpIdx
);
  localparam int CNT_W = $clog2(HDR_LEN + 1);
  localparam int IDX_W = $clog2(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(HDR_LEN - 1);
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_TAIL} state_t;

  state_t          state, stateNext;
  logic [CNT_W-1:0] byteCnt, byteCntNext;
  logic [CNT_W-1:0] curIdx;
  logic            take, lastHdr;

  always_comb begin
    strb        = '0;
    cmpIdx      = '0;
    stateNext   = state;
    byteCntNext = byteCnt;
    curIdx      = rxSof ? '0 : byteCnt;
    take        = rxValid && (rxSof || state == S_HDR);
    lastHdr     = (curIdx == LAST_IDX);
    if (take) begin
      strb.startFrame  = rxSof;
      strb.cmpEn       = (curIdx < ADDR_END);
      cmpIdx           = curIdx[IDX_W-1:0];
      strb.issue       = lastHdr || rxEof;
      strb.forceReject = rxEof && !lastHdr;
      byteCntNext      = curIdx + 1'b1;
      if (lastHdr)    stateNext = rxEof ? S_IDLE : S_TAIL;
      else if (rxEof) stateNext = S_IDLE;
      else            stateNext = S_HDR;
    end else if (state == S_TAIL && rxValid && rxEof) begin
      stateNext = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      byteCnt <= '0;
    end else begin
      state   <= stateNext;
      byteCnt <= byteCntNext;
    end
  end
endmodule

// File: rtl/macflt_datapath.sv
module macflt_datapath
  import macflt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int REG_W      = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic                          regSel,
  input  logic [REG_W-1:0]              regWrData,
  output logic [REG_W-1:0]              regRdData,
  input  logic                          promiscMode,
  input  logic                          bcastReject,
  input  logic [7:0]                    rxByte,
  input  ctrlStrobes_t                  strb,
  input  logic [$clog2(ADDR_BYTES)-1:0] cmpIdx,
  output logic                          verdictValid,
  output logic                          verdictAccept
);
  localparam int LO_BYTES = REG_W / 8;
  localparam int IDX_W    = $clog2(ADDR_BYTES);

  logic [7:0] addrByte [ADDR_BYTES];
  logic [7:0] addrSel;
  logic [REG_W-1:0] loImage, hiImage;
  logic stationHit, bcastHit, modePro, modeBrj, acceptNow;

  // per-byte address storage, each byte owned by one register word
  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_addr
    localparam bit IN_HI = (i >= LO_BYTES);
    localparam int LANE  = IN_HI ? i - LO_BYTES : i;
    always_ff @(posedge clk) begin
      if (!rstN)                            addrByte[i] <= '0;
      else if (regWrEn && (regSel == IN_HI)) addrByte[i] <= regWrData[8*LANE +: 8];
    end
  end

  always_comb begin
    loImage = '0;
    hiImage = '0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (i < LO_BYTES) loImage[8*i +: 8]              = addrByte[i];
      else              hiImage[8*(i-LO_BYTES) +: 8]   = addrByte[i];
    end
    regRdData = regSel ? hiImage : loImage;
  end

  always_comb begin
    addrSel = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (cmpIdx == IDX_W'(i)) addrSel = addrByte[i];
  end

  assign acceptNow = modePro || stationHit || (bcastHit && !modeBrj);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stationHit    <= 1'b0;
      bcastHit      <= 1'b0;
      modePro       <= 1'b0;
      modeBrj       <= 1'b0;
      verdictValid  <= 1'b0;
      verdictAccept <= 1'b0;
    end else begin
      if (strb.startFrame) begin
        modePro <= promiscMode;
        modeBrj <= bcastReject;
      end
      if (strb.cmpEn) begin
        stationHit <= (strb.startFrame || stationHit) && (rxByte == addrSel);
        bcastHit   <= (strb.startFrame || bcastHit) && (rxByte == 8'hFF);
      end
      verdictValid  <= strb.issue;
      verdictAccept <= strb.issue && !strb.forceReject && acceptNow;
    end
  end
endmodule

// File: rtl/mac_dest_filter.sv
module mac_dest_filter
  import macflt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HDR_LEN    = 14,
  parameter int REG_W      = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             promiscMode,
  input  logic             bcastReject,
  input  logic             rxValid,
  input  logic             rxSof,
  input  logic             rxEof,
  input  logic [7:0]       rxByte,
  output logic             verdictValid,
  output logic             verdictAccept
);
  localparam int IDX_W = $clog2(ADDR_BYTES);

  ctrlStrobes_t     strb;
  logic [IDX_W-1:0] cmpIdx;

  macflt_ctrl #(.ADDR_BYTES(ADDR_BYTES), .HDR_LEN(HDR_LEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof),
    .strb(strb), .cmpIdx(cmpIdx)
  );

  macflt_datapath #(.ADDR_BYTES(ADDR_BYTES), .REG_W(REG_W)) i_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData),
    .promiscMode(promiscMode), .bcastReject(bcastReject), .rxByte(rxByte),
    .strb(strb), .cmpIdx(cmpIdx),
    .verdictValid(verdictValid), .verdictAccept(verdictAccept)
  );
endmodule

// File: rtl/macflt_checker.sv
module macflt_checker #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic             regSel,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] regRdData,
  input logic             rxValid,
  input logic             rxSof,
  input logic             rxEof,
  input logic             verdictValid,
  input logic             verdictAccept
);
  p_accept_needs_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    verdictAccept |-> verdictValid);

  p_hi_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    regSel |-> (regRdData[REG_W-1:16] == '0));

  p_lo_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel) |=> (regSel || regRdData == $past(regWrData)));

  p_single_byte_reject_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxSof && rxEof) |=> (verdictValid && !verdictAccept));

  p_no_verdict_on_open_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxSof && !rxEof) |=> !verdictValid);
endmodule

bind mac_dest_filter macflt_checker #(.REG_W(REG_W)) u_chk (.*);

// File: tb/test_mac_dest_filter.sv
module test_mac_dest_filter;
  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 0, regSel = 0;
  logic [31:0] regWrData = '0, regRdData;
  logic promiscMode = 0, bcastReject = 0;
  logic rxValid = 0, rxSof = 0, rxEof = 0;
  logic [7:0] rxByte = '0;
  logic verdictValid, verdictAccept;

  int cyc = 0, checks = 0, fails = 0;
  int pulses = 0, pulseCyc = 0;
  logic lastAcc = 0;

  always #5 clk = ~clk;

  mac_dest_filter i_mac_dest_filter (.*);

  localparam logic [47:0] STATION = 48'h5544_3322_1102; // byte i in bits 8i+7:8i
  localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] OTHER   = 48'h0A0B_0C0D_0E0F;

  typedef struct packed {
    logic [47:0] dest; logic [7:0] len; logic pro; logic brj;
    logic expAcc; logic [1:0] gap; logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{STATION,           8'd14, 1'b0, 1'b0, 1'b1, 2'd0, 4'd4},  // R4
    '{STATION,           8'd60, 1'b0, 1'b0, 1'b1, 2'd1, 4'd12}, // R12
    '{48'h5644_3322_1102, 8'd20, 1'b0, 1'b0, 1'b0, 2'd0, 4'd5}, // R5 last byte
    '{48'h5544_3322_1103, 8'd14, 1'b0, 1'b0, 1'b0, 2'd0, 4'd5}, // R5 first byte
    '{48'h0211_2233_4455, 8'd14, 1'b0, 1'b0, 1'b0, 2'd0, 4'd4}, // R4 order
    '{BCAST,             8'd14, 1'b0, 1'b0, 1'b1, 2'd0, 4'd6},  // R6
    '{BCAST,             8'd14, 1'b0, 1'b1, 1'b0, 2'd0, 4'd6},  // R6
    '{OTHER,             8'd20, 1'b1, 1'b0, 1'b1, 2'd0, 4'd7},  // R7
    '{BCAST,             8'd20, 1'b1, 1'b1, 1'b1, 2'd0, 4'd7},  // R7
    '{STATION,           8'd13, 1'b0, 1'b0, 1'b0, 2'd0, 4'd8},  // R8
    '{OTHER,             8'd5,  1'b1, 1'b0, 1'b0, 2'd0, 4'd8},  // R8
    '{STATION,           8'd1,  1'b1, 1'b0, 1'b0, 2'd0, 4'd8},  // R8
    '{STATION,           8'd14, 1'b0, 1'b1, 1'b1, 2'd0, 4'd6},  // R6
    '{OTHER,             8'd30, 1'b1, 1'b0, 1'b1, 2'd2, 4'd12}  // R12
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      finishUp();
    end
  end

  always @(negedge clk)
    if (verdictValid) begin
      pulses++; lastAcc = verdictAccept; pulseCyc = cyc;
    end

  task automatic regWrite(input bit sel, input logic [31:0] d);
    @(negedge clk); #1;
    regWrEn = 1; regSel = sel; regWrData = d;
    @(negedge clk); #1;
    regWrEn = 0;
  endtask

  // drives a frame; flips both mode inputs at byte flipAt (-1: never)
  task automatic sendFrame(input logic [47:0] dest, input int len, input int gap,
                           input int flipAt, output int sofCyc);
    @(negedge clk); #1;
    pulses = 0; sofCyc = cyc;
    for (int k = 0; k < len; k++) begin
      if (k == flipAt) begin promiscMode = ~promiscMode; bcastReject = ~bcastReject; end
      rxValid = 1; rxSof = (k == 0); rxEof = (k == len - 1);
      rxByte = (k < 6) ? dest[8*k +: 8] : 8'(8'hA0 + k);
      @(negedge clk); #1;
      rxValid = 0; rxSof = 0; rxEof = 0;
      if (k != len - 1)
        for (int g = 0; g < gap; g++) begin @(negedge clk); #1; end
    end
    for (int w = 0; w < 3; w++) begin @(negedge clk); #1; end
  endtask

  task automatic partial(input logic [47:0] dest, input int n);
    @(negedge clk); #1;
    for (int k = 0; k < n; k++) begin
      rxValid = 1; rxSof = (k == 0); rxEof = 0; rxByte = dest[8*k +: 8];
      @(negedge clk); #1;
    end
    rxValid = 0; rxSof = 0;
  endtask

  initial begin
    int sc, d, expCyc;
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    @(negedge clk); #1;
    // R3 reset state
    regSel = 0; #1 check(regRdData == 0, "R3", "low reg after reset", regRdData, 0);
    regSel = 1; #1 check(regRdData == 0, "R3", "high reg after reset", regRdData, 0);
    check(verdictValid == 0, "R3", "verdict after reset", verdictValid, 0);

    // R1 / R2 register packing
    regWrite(0, 32'h3322_1102);
    regSel = 0; #1 check(regRdData == 32'h3322_1102, "R1", "low reg read", regRdData, 32'h3322_1102);
    regWrite(1, 32'hDEAD_5544);
    regSel = 1; #1 check(regRdData == 32'h0000_5544, "R2", "high reg read", regRdData, 32'h5544);

    foreach (VECS[i]) begin
      promiscMode = VECS[i].pro; bcastReject = VECS[i].brj;
      sendFrame(VECS[i].dest, int'(VECS[i].len), int'(VECS[i].gap), -1, sc);
      d = (int'(VECS[i].len) < 14 ? int'(VECS[i].len) : 14) - 1;
      expCyc = sc + 1 + d * (1 + int'(VECS[i].gap));
      check(pulses == 1, "R9", $sformatf("row %0d pulse count", i), pulses, 1);
      check(lastAcc == VECS[i].expAcc, $sformatf("R%0d", VECS[i].req),
            $sformatf("row %0d verdict", i), lastAcc, VECS[i].expAcc);
      check(pulseCyc == expCyc, "R9", $sformatf("row %0d verdict cycle", i), pulseCyc, expCyc);
    end

    // R10: modes flipped mid-frame are ignored
    promiscMode = 0; bcastReject = 0;
    sendFrame(OTHER, 20, 0, 3, sc);
    check(pulses == 1 && lastAcc == 0, "R10", "promisc raised mid-frame", lastAcc, 0);
    promiscMode = 0; bcastReject = 0;
    sendFrame(BCAST, 20, 0, 2, sc);
    check(pulses == 1 && lastAcc == 1, "R10", "bcast reject raised mid-frame", lastAcc, 1);

    // R11: restart mid-frame
    promiscMode = 0; bcastReject = 0;
    partial(STATION, 4);
    sendFrame(OTHER, 14, 0, -1, sc);
    check(pulses == 1 && lastAcc == 0, "R11", "restart onto foreign frame", lastAcc, 0);
    partial(OTHER, 9);
    sendFrame(STATION, 16, 0, -1, sc);
    check(pulses == 1 && lastAcc == 1, "R11", "restart onto matching frame", lastAcc, 1);
    check(pulseCyc == sc + 14, "R11", "restart verdict cycle", pulseCyc, sc + 14);

    finishUp();
  end
endmodule